// File: doc/BRIEF.md
# Instruction skip-mask sequencer

This block sits between instruction fetch and execute in a small processor pipeline. A SKIP instruction loads a 32-bit mask into it. From the next instruction on, the block reads the mask one bit per executed slot, starting at the least significant bit. A set bit cancels that instruction and a clear bit lets it run. The slots follow execution order, so after a taken branch the next bit applies to the instruction at the branch target.

In local-exec mode a cancelled slot also moves the program counter past the cancelled instruction and up to seven more consecutive cancelled ones. It does this with an 8-bit look-ahead window, so the PC step is 1 to 8. In streaming mode the fetch path must never restart, so cancelled instructions are only suppressed and the PC keeps its fixed step of 4. While any unconsumed set bit remains, the block holds interrupts off.

Top module: `skip_seq`

## Requirements
- R1: After reset the mask is empty, irq_inhibit_o is 0, and cancel_o is 0 for every instruction.
- R2: For each valid instruction, cancel_o equals the lowest unconsumed mask bit (1 = cancel, 0 = execute) in the same cycle. Bits are consumed least significant bit first, starting with the instruction after the loading SKIP.
- R3: A valid instruction with load_i = 1 that is not cancelled puts mask_i in place of any remaining mask. The new bit 0 applies to the next valid instruction.
- R4: A load_i on a cancelled instruction has no effect. The old mask keeps being consumed as if load_i were 0.
- R5: In local mode (mode_i = 0), a cancelled slot gives pc_inc_o = the number of consecutive set bits starting at the current bit, counting at most 8. That many bits are consumed. A run of 32 set bits therefore takes four cancelled slots, each with an increment of 8.
- R6: In local mode an executed, non-branching instruction gives pc_inc_o = 1 and consumes one bit. In streaming mode (mode_i = 1) pc_inc_o is 4 for every instruction that is not an executed taken branch, cancelled or not, and every valid slot consumes exactly one bit.
- R7: A taken branch (branch_i = 1) on an executed instruction gives pc_inc_o = 0 and consumes one bit, so skipping continues at the branch target. branch_i on a cancelled instruction is ignored.
- R8: irq_inhibit_o is 1 exactly while any unconsumed mask bit is 1. The sequence ends on its own once the remaining bits are all zero.
- R9: In a cycle with inst_valid_i = 0, cancel_o is 0, no bit is consumed and no load happens.
- R10: seq_pc_o always equals pc_i + pc_inc_o, truncated to the PC width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inst_valid_i | input | 1 | An instruction is in execute this cycle |
| load_i | input | 1 | The instruction in execute is a SKIP |
| mask_i | input | 32 | Skip mask carried by the SKIP instruction |
| mode_i | input | 1 | 0 = local exec, 1 = streaming exec |
| branch_i | input | 1 | The instruction in execute would take a branch |
| pc_i | input | 20 | PC of the instruction in execute |
| cancel_o | output | 1 | Suppress all side effects of the instruction in execute |
| pc_inc_o | output | 4 | Sequential PC increment (0 on an executed taken branch) |
| seq_pc_o | output | 20 | pc_i + pc_inc_o |
| irq_inhibit_o | output | 1 | Hold off interrupts while the skip sequence is active |

## Verification
Two events can fall in the same cycle: a cancellation and either a new SKIP load or a taken branch. The bench provokes both collisions. It issues a SKIP and a branching instruction on slots whose mask bit is 1, and on slots whose bit is 0, in both exec modes. A scoreboard model that advances one slot at a time predicts each result. The bench then checks that the cancelled SKIP leaves the old mask running and that the cancelled branch keeps the look-ahead increment. An executed branch must give a zero increment and consume exactly one bit, and an executed SKIP must restart consumption from the new mask's bit 0.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef enum logic {
    EXEC_LOCAL  = 1'b0,
    EXEC_STREAM = 1'b1
  } exec_mode_e;
endpackage

// File: rtl/skip_lookahead.sv
// Counts consecutive ones from bit 0 of a bounded window (saturates at WIN_W).
module skip_lookahead #(
  parameter int WIN_W = 8,
  localparam int CNT_W = $clog2(WIN_W + 1)
) (
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] run_o
);
  always_comb begin
    run_o = CNT_W'(WIN_W);
    for (int i = WIN_W - 1; i >= 0; i--) begin
      if (!win_i[i]) run_o = CNT_W'(i);
    end
  end
endmodule

// File: rtl/skip_mask_reg.sv
module skip_mask_reg #(
  parameter int MASK_W = 32,
  parameter int SH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              load_i,
  input  logic [MASK_W-1:0] load_val_i,
  output logic [MASK_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_o <= '0;
    else if (load_i) mask_o <= load_val_i;
    else if (adv_i)  mask_o <= mask_o >> shamt_i;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(mask_o)) else $error("mask changed without advance"); // R9

  AST_EMPTY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0 && !load_i) |=> (mask_o == '0)) else $error("empty mask refilled"); // R8
endmodule

// File: rtl/skip_seq.sv
module skip_seq
  import skip_pkg::*;
#(
  parameter int MASK_W   = 32,
  parameter int LOOK_W   = 8,
  parameter int PC_W     = 20,
  parameter int HUB_STEP = 4,
  localparam int RUN_W   = $clog2(LOOK_W + 1),
  localparam int MAX_INC = (LOOK_W > HUB_STEP) ? LOOK_W : HUB_STEP,
  localparam int INC_W   = $clog2(MAX_INC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inst_valid_i,
  input  logic              load_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              mode_i,
  input  logic              branch_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              cancel_o,
  output logic [INC_W-1:0]  pc_inc_o,
  output logic [PC_W-1:0]   seq_pc_o,
  output logic              irq_inhibit_o
);
  logic [MASK_W-1:0] mask_q;
  logic [RUN_W-1:0]  run;
  logic [RUN_W-1:0]  shamt;
  logic              load_eff, branch_eff, adv;
  exec_mode_e        mode;

  assign mode = exec_mode_e'(mode_i);

  skip_lookahead #(.WIN_W(LOOK_W)) u_look (
    .win_i (mask_q[LOOK_W-1:0]),
    .run_o (run)
  );

  assign cancel_o      = inst_valid_i & mask_q[0];
  assign load_eff      = inst_valid_i & load_i & ~cancel_o;
  assign branch_eff    = inst_valid_i & branch_i & ~cancel_o;
  assign adv           = inst_valid_i & ~load_eff;
  assign irq_inhibit_o = |mask_q;

  // Local mode jumps the whole run of cancelled slots; streaming consumes one.
  always_comb begin
    shamt = RUN_W'(1);
    if (mode == EXEC_LOCAL && cancel_o) shamt = run;
  end

  always_comb begin
    if (branch_eff)               pc_inc_o = '0;
    else if (mode == EXEC_STREAM) pc_inc_o = INC_W'(HUB_STEP);
    else if (cancel_o)            pc_inc_o = INC_W'(run);
    else                          pc_inc_o = INC_W'(1);
  end

  assign seq_pc_o = pc_i + PC_W'(pc_inc_o);

  skip_mask_reg #(.MASK_W(MASK_W), .SH_W(RUN_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .shamt_i    (shamt),
    .load_i     (load_eff),
    .load_val_i (mask_i),
    .mask_o     (mask_q)
  );

  AST_CANCEL_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> irq_inhibit_o) else $error("cancel while idle"); // R8

  AST_STREAM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !(inst_valid_i && branch_i && !cancel_o)) |-> (pc_inc_o == INC_W'(HUB_STEP)))
    else $error("streaming step altered"); // R6

  AST_LOCAL_JUMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && cancel_o) |-> (pc_inc_o >= 1 && pc_inc_o <= INC_W'(LOOK_W)))
    else $error("local jump out of range"); // R5

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_valid_i && load_i && !cancel_o) |=> (irq_inhibit_o == (|$past(mask_i))))
    else $error("executed load not taken"); // R3

  AST_NO_CANCEL_IDLE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst_valid_i |-> !cancel_o) else $error("cancel without instruction"); // R9

  AST_BRANCH_ZERO_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_valid_i && branch_i && !cancel_o) |-> (pc_inc_o == '0))
    else $error("branch increment nonzero"); // R7
endmodule

// File: tb/skip_seq_bench.sv
`timescale 1ns/1ps
module skip_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, load = 1'b0, mode = 1'b0, branch = 1'b0;
  logic [31:0] mask = '0;
  logic [19:0] pc = '0;
  logic        cancel, inh;
  logic [3:0]  inc;
  logic [19:0] spc;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic        c;
    logic [3:0]  inc;
    logic        inh;
    logic [19:0] spc;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_mask = '0;
  logic [19:0] m_pc = 20'h100;

  always #4 clk = ~clk;

  skip_seq u_skip_seq (
    .clk_i(clk), .rst_ni(rst_n), .inst_valid_i(valid), .load_i(load), .mask_i(mask),
    .mode_i(mode), .branch_i(branch), .pc_i(pc), .cancel_o(cancel), .pc_inc_o(inc),
    .seq_pc_o(spc), .irq_inhibit_o(inh)
  );

  function automatic int ones_run(input logic [31:0] m);
    int n = 0;
    for (int i = 0; i < 8; i++) begin
      if (m[i] && n == i) n++;
    end
    return n;
  endfunction

  task automatic issue(input logic v, input logic ld, input logic [31:0] mv,
                       input logic md, input logic br, input string tag);
    exp_t e;
    logic c, b_eff;
    int run, step;
    @(posedge clk);
    #1;
    valid = v; load = ld; mask = mv; mode = md; branch = br; pc = m_pc;
    c     = v && m_mask[0];
    b_eff = v && br && !c;
    run   = ones_run(m_mask);
    if (b_eff)     step = 0;
    else if (md)   step = 4;
    else if (c)    step = run;
    else           step = 1;
    e.c = c; e.inc = 4'(step); e.inh = (m_mask != 0); e.spc = m_pc + 20'(step); e.tag = tag;
    q.push_back(e);
    if (v) begin
      if (c)       m_mask = m_mask >> (md ? 1 : run);
      else if (ld) m_mask = mv;
      else         m_mask = m_mask >> 1;
    end
    if (b_eff) m_pc = m_pc + 20'h40;
    else       m_pc = m_pc + 20'(step);
  endtask

  task automatic run_plain(input int n, input logic md, input string tag);
    for (int i = 0; i < n; i++) issue(1'b1, 1'b0, '0, md, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (cancel !== e.c || inc !== e.inc || inh !== e.inh) begin
        n_fail++;
        $display("FAIL %s: cancel/inc/inhibit got %b/%0d/%b exp %b/%0d/%b",
                 e.tag, cancel, inc, inh, e.c, e.inc, e.inh);
      end
      n_tests++;
      if (spc !== e.spc) begin
        n_fail++;
        $display("FAIL R10: seq_pc got %h exp %h", spc, e.spc);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle after reset
    run_plain(3, 1'b0, "R1");
    run_plain(2, 1'b1, "R1");
    // R2 R5 R8: bits 31 and 0, local
    issue(1'b1, 1'b1, 32'h8000_0001, 1'b0, 1'b0, "R3");
    run_plain(34, 1'b0, "R2");
    // same mask, streaming
    issue(1'b1, 1'b1, 32'h8000_0001, 1'b1, 1'b0, "R3");
    run_plain(34, 1'b1, "R6");
    // alternating patterns
    issue(1'b1, 1'b1, 32'hAAAA_AAAA, 1'b0, 1'b0, "R3");
    run_plain(34, 1'b0, "R2");
    issue(1'b1, 1'b1, 32'h5555_5555, 1'b0, 1'b0, "R3");
    run_plain(34, 1'b0, "R5");
    issue(1'b1, 1'b1, 32'h5555_5555, 1'b1, 1'b0, "R3");
    run_plain(34, 1'b1, "R6");
    // 32 ones: local needs four slots of 8, streaming 32 slots of 4
    issue(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3");
    run_plain(6, 1'b0, "R5");
    issue(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R3");
    run_plain(34, 1'b1, "R6");
    // run longer than window mixed with gaps
    issue(1'b1, 1'b1, 32'h0003_FFF2, 1'b0, 1'b0, "R3");
    run_plain(8, 1'b0, "R5");
    // taken branch mid-sequence: executed and cancelled, both modes
    issue(1'b1, 1'b1, 32'h0000_0F62, 1'b0, 1'b0, "R3");
    issue(1'b1, 1'b0, '0, 1'b0, 1'b1, "R7");
    issue(1'b1, 1'b0, '0, 1'b0, 1'b1, "R7");
    issue(1'b1, 1'b0, '0, 1'b0, 1'b1, "R7");
    run_plain(6, 1'b0, "R7");
    issue(1'b1, 1'b1, 32'h0000_0036, 1'b1, 1'b0, "R3");
    issue(1'b1, 1'b0, '0, 1'b1, 1'b1, "R7");
    issue(1'b1, 1'b0, '0, 1'b1, 1'b1, "R7");
    run_plain(6, 1'b1, "R7");
    // gaps with no valid instruction hold state
    issue(1'b1, 1'b1, 32'h0000_0015, 1'b0, 1'b0, "R3");
    issue(1'b0, 1'b0, '0, 1'b0, 1'b0, "R9");
    issue(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, "R9");
    run_plain(2, 1'b0, "R9");
    issue(1'b0, 1'b0, '0, 1'b1, 1'b0, "R9");
    run_plain(4, 1'b0, "R9");
    // reload while active (executed) and load on a cancelled slot (ignored)
    issue(1'b1, 1'b1, 32'h0000_00F4, 1'b0, 1'b0, "R3");
    issue(1'b1, 1'b1, 32'h0000_0003, 1'b0, 1'b0, "R3");
    run_plain(4, 1'b0, "R3");
    issue(1'b1, 1'b1, 32'h0000_0005, 1'b0, 1'b0, "R3");
    issue(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4");
    run_plain(4, 1'b0, "R4");
    issue(1'b1, 1'b1, 32'h0000_0003, 1'b1, 1'b0, "R3");
    issue(1'b1, 1'b1, 32'hFFFF_0000, 1'b1, 1'b0, "R4");
    run_plain(3, 1'b1, "R4");
    // zero mask load is an immediate end
    issue(1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, "R8");
    run_plain(2, 1'b0, "R8");
    repeat (3) @(posedge clk);
    #1 valid = 1'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule